// File: doc/BRIEF.md
# Banked Masked Control Register File

This block is the system-control register file of a small multithreaded core. It is addressed by a 5-bit register number and a 3-bit select. Each implemented register belongs to one of three classes. A shared register has one copy for the whole core. A per-virtual-processor register has one copy for each virtual processor. A per-thread register has one copy for each hardware thread context.

Software writes go through a per-register write mask. Bits outside the mask keep their stored value, so read-only fields survive any software store. A second, privileged port writes raw values and replaces write masks directly, with no filtering. Reads are combinational and return both the selected value and its mask.

Reset loads the configured start-up state in one step: initial field values, the per-register masks and the thread bindings. All other registers read zero.

Top module: `cpr_regfile`

## Requirements
- R1: The flat index is register number × 8 + select. A read returns the stored value in the same cycle, with no register stage. A write to one index leaves the neighbouring indices untouched.
- R2: Shared registers have a single copy. A value written by any thread is read back by every thread. The shared registers are 0/0, 0/2, 1/0, 2/0, 3/0, 4/0, 5/0, 5/1, 8/0, 12/1, 12/2, 13/0, 15/0, and 16/0 to 16/3.
- R3: A software write stores (wdata & mask) | (current & ~mask).
- R4: Registers 15/0, 16/1, 16/3, 1/0, 8/0 and 17/0 have a zero mask after reset, so software writes leave them unchanged.
- R5: Per-thread registers 12/0, 2/1, 2/2, 2/4 and 17/0 are banked by the requesting thread id.
- R6: Per-virtual-processor registers 1/1, 1/2 and 15/1 are banked by bits 3:0 of the requesting thread's binding register 2/2. A bank number at or above NUM_VPES reads zero and ignores writes. With NUM_VPES = 1 these registers are not replicated.
- R7: After reset, the following values hold:
  - 12/0 has bits 2 and 22 set.
  - 1/0 holds 63.
  - 15/1 has bit 31 set.
  - 0/2 holds bit 15 = 1, bits 13:10 = NUM_VPES−1 and bits 7:0 = NUM_THREADS−1.
  - 1/2 has bit 1 set.
  - Each thread's 2/2 has its own id in bits 28:21.
  - Thread 0's 2/1 has bit 13 set. Every other thread's 2/1 has bit 15 set.
  - The masks are: 12/0 FF78FF17, 13/0 08C00300, 16/0 7FFF0007, 16/2 7000F000, 15/1 3FFFF000, 12/2 0000F3C0, 12/1 000003E0, 0/0 7FFFFFFF, 2/0 and 3/0 3FFFFFFF, 4/0 FF800000, 5/0 1FFFF800, 5/1 10000000.
  - The zero masks of R4 apply. All other masks are all-ones and all other values are zero.
- R8: The privileged port writes values and masks unfiltered. When it and a software write hit the same register copy in one cycle, the privileged value is stored.
- R9: Unimplemented number/select pairs read zero for both value and mask, and writes to them change nothing.
- R10: In a cycle with no write on either port, no value or mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_tid | input | TID_W | Thread id of the read request |
| rd_num | input | 5 | Register number to read |
| rd_sel | input | 3 | Select to read |
| rd_data | output | 32 | Value of the addressed register copy |
| rd_mask | output | 32 | Write mask of the addressed register copy |
| sw_we | input | 1 | Software (masked) write enable |
| sw_tid | input | TID_W | Thread id of the software write |
| sw_num | input | 5 | Register number of the software write |
| sw_sel | input | 3 | Select of the software write |
| sw_wdata | input | 32 | Software write data |
| raw_we | input | 1 | Privileged raw value write enable |
| raw_mask_we | input | 1 | Privileged mask write enable |
| raw_tid | input | TID_W | Thread id of the privileged access |
| raw_num | input | 5 | Register number of the privileged access |
| raw_sel | input | 3 | Select of the privileged access |
| raw_wdata | input | 32 | Raw value to store |
| raw_wmask | input | 32 | Write mask to store |

## Verification
Some properties are checked on every cycle. Bits outside the mask are held through a software write. A privileged value or mask lands exactly one cycle after it is driven. Unmapped reads return zero. Nothing moves in a cycle without a write.

Other behaviour can be shown only by the bench's scenarios:
- the reset constants and masks;
- per-thread and per-virtual-processor bank separation;
- rebinding a thread to another virtual-processor bank, including an out-of-range bank;
- the same-cycle collision between the two write ports.

// File: rtl/cpr_pkg.sv
`timescale 1ns/1ps
package cpr_pkg;

    localparam int XLEN = 32;

    // Class of each implemented register.
    typedef enum logic [1:0] {K_NONE, K_SHARED, K_VPE, K_TC} kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [4:0] slot;
    } regmap_t;

    // Shared register slots.
    localparam int SH_TLB_IDX    = 0;
    localparam int SH_CORE_CFG   = 1;
    localparam int SH_RAND       = 2;
    localparam int SH_PTE0       = 3;
    localparam int SH_PTE1       = 4;
    localparam int SH_PTE_CTX    = 5;
    localparam int SH_PGSIZE     = 6;
    localparam int SH_PGGRAIN    = 7;
    localparam int SH_FAULT_VA   = 8;
    localparam int SH_IRQ_CTL    = 9;
    localparam int SH_SHADOW_CTL = 10;
    localparam int SH_TRAP_CAUSE = 11;
    localparam int SH_CPU_ID     = 12;
    localparam int SH_CFG0       = 13;
    localparam int SH_CFG1       = 14;
    localparam int SH_CFG2       = 15;
    localparam int SH_CFG3       = 16;
    localparam int N_SH          = 17;

    // Per-virtual-processor register slots.
    localparam int VR_CTRL     = 0;
    localparam int VR_CFG      = 1;
    localparam int VR_VEC_BASE = 2;
    localparam int N_VR        = 3;

    // Per-thread register slots.
    localparam int TR_MODE      = 0;
    localparam int TR_STATE     = 1;
    localparam int TR_BIND      = 2;
    localparam int TR_HALT      = 3;
    localparam int TR_LINK_ADDR = 4;
    localparam int N_TR         = 5;

    // Flat index = number*8 + select.
    function automatic regmap_t lookup(input logic [7:0] idx);
        regmap_t m;
        m = '{kind: K_NONE, slot: 5'd0};
        case (idx)
            8'd0:   m = '{K_SHARED, 5'(SH_TLB_IDX)};
            8'd2:   m = '{K_SHARED, 5'(SH_CORE_CFG)};
            8'd8:   m = '{K_SHARED, 5'(SH_RAND)};
            8'd9:   m = '{K_VPE,    5'(VR_CTRL)};
            8'd10:  m = '{K_VPE,    5'(VR_CFG)};
            8'd16:  m = '{K_SHARED, 5'(SH_PTE0)};
            8'd17:  m = '{K_TC,     5'(TR_STATE)};
            8'd18:  m = '{K_TC,     5'(TR_BIND)};
            8'd20:  m = '{K_TC,     5'(TR_HALT)};
            8'd24:  m = '{K_SHARED, 5'(SH_PTE1)};
            8'd32:  m = '{K_SHARED, 5'(SH_PTE_CTX)};
            8'd40:  m = '{K_SHARED, 5'(SH_PGSIZE)};
            8'd41:  m = '{K_SHARED, 5'(SH_PGGRAIN)};
            8'd64:  m = '{K_SHARED, 5'(SH_FAULT_VA)};
            8'd96:  m = '{K_TC,     5'(TR_MODE)};
            8'd97:  m = '{K_SHARED, 5'(SH_IRQ_CTL)};
            8'd98:  m = '{K_SHARED, 5'(SH_SHADOW_CTL)};
            8'd104: m = '{K_SHARED, 5'(SH_TRAP_CAUSE)};
            8'd120: m = '{K_SHARED, 5'(SH_CPU_ID)};
            8'd121: m = '{K_VPE,    5'(VR_VEC_BASE)};
            8'd128: m = '{K_SHARED, 5'(SH_CFG0)};
            8'd129: m = '{K_SHARED, 5'(SH_CFG1)};
            8'd130: m = '{K_SHARED, 5'(SH_CFG2)};
            8'd131: m = '{K_SHARED, 5'(SH_CFG3)};
            8'd136: m = '{K_TC,     5'(TR_LINK_ADDR)};
            default: m = '{K_NONE, 5'd0};
        endcase
        return m;
    endfunction

    function automatic logic [XLEN-1:0] shared_rst_val(input int slot, input int nt, input int nv);
        logic [XLEN-1:0] v;
        v = '0;
        if (slot == SH_CORE_CFG) begin
            v[15]    = 1'b1;
            v[13:10] = 4'(nv - 1);
            v[7:0]   = 8'(nt - 1);
        end else if (slot == SH_RAND) begin
            v = 32'd63;
        end
        return v;
    endfunction

    function automatic logic [XLEN-1:0] shared_rst_mask(input int slot);
        case (slot)
            SH_TLB_IDX:    return 32'h7FFF_FFFF;
            SH_PTE0:       return 32'h3FFF_FFFF;
            SH_PTE1:       return 32'h3FFF_FFFF;
            SH_PTE_CTX:    return 32'hFF80_0000;
            SH_PGSIZE:     return 32'h1FFF_F800;
            SH_PGGRAIN:    return 32'h1000_0000;
            SH_IRQ_CTL:    return 32'h0000_03E0;
            SH_SHADOW_CTL: return 32'h0000_F3C0;
            SH_TRAP_CAUSE: return 32'h08C0_0300;
            SH_CFG0:       return 32'h7FFF_0007;
            SH_CFG2:       return 32'h7000_F000;
            SH_CPU_ID, SH_CFG1, SH_CFG3, SH_RAND, SH_FAULT_VA: return 32'h0;
            default:       return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] vpe_rst_val(input int slot);
        if (slot == VR_CFG)      return 32'h0000_0002;
        if (slot == VR_VEC_BASE) return 32'h8000_0000;
        return 32'h0;
    endfunction

    function automatic logic [XLEN-1:0] vpe_rst_mask(input int slot);
        if (slot == VR_VEC_BASE) return 32'h3FFF_F000;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [XLEN-1:0] tc_rst_val(input int slot, input int tid);
        logic [XLEN-1:0] v;
        v = '0;
        if (slot == TR_MODE) begin
            v[2]  = 1'b1;
            v[22] = 1'b1;
        end else if (slot == TR_STATE) begin
            if (tid == 0) v[13] = 1'b1;
            else          v[15] = 1'b1;
        end else if (slot == TR_BIND) begin
            v[28:21] = 8'(tid);
        end
        return v;
    endfunction

    function automatic logic [XLEN-1:0] tc_rst_mask(input int slot);
        if (slot == TR_MODE)      return 32'hFF78_FF17;
        if (slot == TR_LINK_ADDR) return 32'h0;
        return 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/cpr_locate.sv
`timescale 1ns/1ps
module cpr_locate #(
    parameter int NT    = 2,
    parameter int NV    = 2,
    parameter int TID_W = 1,
    parameter int EW    = 6
) (
    input  logic [4:0]          num,
    input  logic [2:0]          sel,
    input  logic [TID_W-1:0]    tid,
    input  logic [NT-1:0][3:0]  bind_vpe,
    output logic                hit,
    output logic [EW-1:0]       entry
);
    import cpr_pkg::*;

    localparam int VPE_BASE = N_SH;
    localparam int TC_BASE  = N_SH + N_VR * NV;

    regmap_t    map;
    logic       tid_ok;
    logic [3:0] vpe;
    logic       vbank_ok;
    int         vbank;

    assign map    = lookup({num, sel});
    assign tid_ok = int'(tid) < NT;
    assign vpe    = tid_ok ? bind_vpe[tid] : 4'd0;

    generate
        if (NV == 1) begin : g_single_vpe
            assign vbank_ok = 1'b1;
            assign vbank    = 0;
        end else begin : g_multi_vpe
            assign vbank_ok = int'(vpe) < NV;
            assign vbank    = int'(vpe);
        end
    endgenerate

    always_comb begin
        hit   = 1'b0;
        entry = '0;
        case (map.kind)
            K_SHARED: begin
                hit   = 1'b1;
                entry = EW'(int'(map.slot));
            end
            K_VPE: begin
                hit   = tid_ok && vbank_ok;
                entry = EW'(VPE_BASE + int'(map.slot) * NV + vbank);
            end
            K_TC: begin
                hit   = tid_ok;
                entry = EW'(TC_BASE + int'(map.slot) * NT + int'(tid));
            end
            default: begin
                hit   = 1'b0;
                entry = '0;
            end
        endcase
    end
endmodule

// File: rtl/cpr_merge.sv
`timescale 1ns/1ps
module cpr_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] merged
);
    // Writable bits come from the new data, locked bits keep the old value.
    assign merged = (wdata & mask) | (cur & ~mask);
endmodule

// File: rtl/cpr_regfile.sv
`timescale 1ns/1ps
module cpr_regfile #(
    parameter int NUM_THREADS = 2,
    parameter int NUM_VPES    = 2,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TID_W-1:0]         rd_tid,
    input  logic [4:0]               rd_num,
    input  logic [2:0]               rd_sel,
    output logic [cpr_pkg::XLEN-1:0] rd_data,
    output logic [cpr_pkg::XLEN-1:0] rd_mask,
    input  logic                     sw_we,
    input  logic [TID_W-1:0]         sw_tid,
    input  logic [4:0]               sw_num,
    input  logic [2:0]               sw_sel,
    input  logic [cpr_pkg::XLEN-1:0] sw_wdata,
    input  logic                     raw_we,
    input  logic                     raw_mask_we,
    input  logic [TID_W-1:0]         raw_tid,
    input  logic [4:0]               raw_num,
    input  logic [2:0]               raw_sel,
    input  logic [cpr_pkg::XLEN-1:0] raw_wdata,
    input  logic [cpr_pkg::XLEN-1:0] raw_wmask
);
    import cpr_pkg::*;

    localparam int N_E      = N_SH + N_VR * NUM_VPES + N_TR * NUM_THREADS;
    localparam int EW       = $clog2(N_E);
    localparam int VPE_BASE = N_SH;
    localparam int TC_BASE  = N_SH + N_VR * NUM_VPES;
    localparam int N_PORTS  = 3; // 0: read, 1: software write, 2: raw access

    typedef struct packed {
        logic [N_E-1:0][XLEN-1:0] val;
        logic [N_E-1:0][XLEN-1:0] mask;
    } state_t;

    function automatic state_t init_state();
        state_t s;
        s = '0;
        for (int i = 0; i < N_SH; i++) begin
            s.val[i]  = shared_rst_val(i, NUM_THREADS, NUM_VPES);
            s.mask[i] = shared_rst_mask(i);
        end
        for (int v = 0; v < N_VR; v++) begin
            for (int b = 0; b < NUM_VPES; b++) begin
                s.val[VPE_BASE + v * NUM_VPES + b]  = vpe_rst_val(v);
                s.mask[VPE_BASE + v * NUM_VPES + b] = vpe_rst_mask(v);
            end
        end
        for (int t = 0; t < N_TR; t++) begin
            for (int b = 0; b < NUM_THREADS; b++) begin
                s.val[TC_BASE + t * NUM_THREADS + b]  = tc_rst_val(t, b);
                s.mask[TC_BASE + t * NUM_THREADS + b] = tc_rst_mask(t);
            end
        end
        return s;
    endfunction

    localparam state_t RST_ST = init_state();

    state_t st_d, st_q;

    logic [N_PORTS-1:0][4:0]       loc_num;
    logic [N_PORTS-1:0][2:0]       loc_sel;
    logic [N_PORTS-1:0][TID_W-1:0] loc_tid;
    logic [N_PORTS-1:0]            loc_hit;
    logic [N_PORTS-1:0][EW-1:0]    loc_ent;
    logic [NUM_THREADS-1:0][3:0]   bind_vpe;
    logic [XLEN-1:0]               sw_merged;

    assign loc_num = {raw_num, sw_num, rd_num};
    assign loc_sel = {raw_sel, sw_sel, rd_sel};
    assign loc_tid = {raw_tid, sw_tid, rd_tid};

    // Bank number of each thread comes from its own binding register.
    generate
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bind
            assign bind_vpe[t] = st_q.val[TC_BASE + TR_BIND * NUM_THREADS + t][3:0];
        end
        for (genvar p = 0; p < N_PORTS; p++) begin : g_loc
            cpr_locate #(
                .NT    (NUM_THREADS),
                .NV    (NUM_VPES),
                .TID_W (TID_W),
                .EW    (EW)
            ) loc_i (
                .num      (loc_num[p]),
                .sel      (loc_sel[p]),
                .tid      (loc_tid[p]),
                .bind_vpe (bind_vpe),
                .hit      (loc_hit[p]),
                .entry    (loc_ent[p])
            );
        end
    endgenerate

    cpr_merge #(.DW(XLEN)) merge_i (
        .cur    (st_q.val[loc_ent[1]]),
        .wdata  (sw_wdata),
        .mask   (st_q.mask[loc_ent[1]]),
        .merged (sw_merged)
    );

    always_comb begin
        st_d = st_q;
        if (sw_we && loc_hit[1]) begin
            st_d.val[loc_ent[1]] = sw_merged;
        end
        // The privileged port is applied last so it wins a collision.
        if (raw_we && loc_hit[2]) begin
            st_d.val[loc_ent[2]] = raw_wdata;
        end
        if (raw_mask_we && loc_hit[2]) begin
            st_d.mask[loc_ent[2]] = raw_wmask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = loc_hit[0] ? st_q.val[loc_ent[0]]  : '0;
    assign rd_mask = loc_hit[0] ? st_q.mask[loc_ent[0]] : '0;

endmodule

// File: rtl/cpr_regfile_chk.sv
`timescale 1ns/1ps
module cpr_regfile_chk #(
    parameter int N_E = 33,
    parameter int EW  = 6
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           sw_we,
    input logic                           raw_we,
    input logic                           raw_mask_we,
    input logic                           sw_hit,
    input logic [EW-1:0]                  sw_e,
    input logic                           raw_hit,
    input logic [EW-1:0]                  raw_e,
    input logic [31:0]                    raw_wdata,
    input logic [31:0]                    raw_wmask,
    input logic [4:0]                     rd_num,
    input logic [2:0]                     rd_sel,
    input logic [31:0]                    rd_data,
    input logic [31:0]                    rd_mask,
    input logic [N_E-1:0][31:0]           val_q,
    input logic [N_E-1:0][31:0]           mask_q
);
    import cpr_pkg::*;

    // R3: bits a software write may not touch keep their previous value.
    a_r3_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && sw_hit && !(raw_we && raw_hit && raw_e == sw_e))
        |=> (((val_q[$past(sw_e)] ^ $past(val_q[sw_e])) & ~$past(mask_q[sw_e])) == 32'h0));

    // R8: a privileged value write lands in the next cycle, whatever else happens.
    a_r8_raw_value_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_we && raw_hit) |=> (val_q[$past(raw_e)] == $past(raw_wdata)));

    // R8: a privileged mask write lands in the next cycle.
    a_r8_raw_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_mask_we && raw_hit) |=> (mask_q[$past(raw_e)] == $past(raw_wmask)));

    // R9: an unmapped pair reads zero for value and mask.
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup({rd_num, rd_sel}).kind == K_NONE) |-> (rd_data == 32'h0 && rd_mask == 32'h0));

    // R10: without any write, the whole state is stable.
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !raw_we && !raw_mask_we) |=> ($stable(val_q) && $stable(mask_q)));

endmodule

bind cpr_regfile cpr_regfile_chk #(.N_E(N_E), .EW(EW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .raw_we      (raw_we),
    .raw_mask_we (raw_mask_we),
    .sw_hit      (loc_hit[1]),
    .sw_e        (loc_ent[1]),
    .raw_hit     (loc_hit[2]),
    .raw_e       (loc_ent[2]),
    .raw_wdata   (raw_wdata),
    .raw_wmask   (raw_wmask),
    .rd_num      (rd_num),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .rd_mask     (rd_mask),
    .val_q       (st_q.val),
    .mask_q      (st_q.mask)
);

// File: tb/cpr_regfile_tb_top.sv
`timescale 1ns/1ps
module cpr_regfile_tb_top;
    localparam int NT = 2;
    localparam int NV = 2;
    localparam int TW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] rd_tid = '0;
    logic [4:0]    rd_num = '0;
    logic [2:0]    rd_sel = '0;
    logic [31:0]   rd_data, rd_mask;
    logic          sw_we = 1'b0;
    logic [TW-1:0] sw_tid = '0;
    logic [4:0]    sw_num = '0;
    logic [2:0]    sw_sel = '0;
    logic [31:0]   sw_wdata = '0;
    logic          raw_we = 1'b0, raw_mask_we = 1'b0;
    logic [TW-1:0] raw_tid = '0;
    logic [4:0]    raw_num = '0;
    logic [2:0]    raw_sel = '0;
    logic [31:0]   raw_wdata = '0, raw_wmask = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cpr_regfile #(.NUM_THREADS(NT), .NUM_VPES(NV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_tid(rd_tid), .rd_num(rd_num), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_mask(rd_mask),
        .sw_we(sw_we), .sw_tid(sw_tid), .sw_num(sw_num), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata),
        .raw_we(raw_we), .raw_mask_we(raw_mask_we), .raw_tid(raw_tid),
        .raw_num(raw_num), .raw_sel(raw_sel),
        .raw_wdata(raw_wdata), .raw_wmask(raw_wmask)
    );

    typedef struct packed {
        logic          wr;
        logic [4:0]    num;
        logic [2:0]    sel;
        logic [TW-1:0] tid;
        logic [31:0]   data;
        logic [31:0]   exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 5'd12, 3'd0, 1'b0, 32'h0,         32'h0040_0004, 4'd7}, // R7 mode reset
        '{1'b0, 5'd1,  3'd0, 1'b0, 32'h0,         32'h0000_003F, 4'd7}, // R7 random 63
        '{1'b0, 5'd15, 3'd1, 1'b0, 32'h0,         32'h8000_0000, 4'd7}, // R7 vector base
        '{1'b0, 5'd0,  3'd2, 1'b0, 32'h0,         32'h0000_8401, 4'd7}, // R7 core config
        '{1'b0, 5'd1,  3'd2, 1'b0, 32'h0,         32'h0000_0002, 4'd7}, // R7 vp config
        '{1'b0, 5'd2,  3'd1, 1'b0, 32'h0,         32'h0000_2000, 4'd7}, // R7 thread 0 active
        '{1'b0, 5'd2,  3'd1, 1'b1, 32'h0,         32'h0000_8000, 4'd7}, // R7 thread 1 allocatable
        '{1'b0, 5'd2,  3'd2, 1'b1, 32'h0,         32'h0020_0000, 4'd7}, // R7 binding thread 1
        '{1'b0, 5'd2,  3'd2, 1'b0, 32'h0,         32'h0000_0000, 4'd7}, // R7 binding thread 0
        '{1'b1, 5'd12, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFF78_FF17, 4'd3}, // R3 mode all ones
        '{1'b1, 5'd12, 3'd0, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd3}, // R3 mode zero
        '{1'b0, 5'd12, 3'd0, 1'b1, 32'h0,         32'h0040_0004, 4'd5}, // R5 other thread bank
        '{1'b1, 5'd13, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'h08C0_0300, 4'd3}, // R3 cause
        '{1'b1, 5'd15, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd4}, // R4 cpu id
        '{1'b1, 5'd1,  3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_003F, 4'd4}, // R4 random
        '{1'b1, 5'd17, 3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 4'd4}, // R4 link address
        '{1'b1, 5'd16, 3'd1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd4}, // R4 cfg1
        '{1'b1, 5'd0,  3'd0, 1'b1, 32'h1234_5678, 32'h1234_5678, 4'd2}, // R2 write by thread 1
        '{1'b0, 5'd0,  3'd0, 1'b0, 32'h0,         32'h1234_5678, 4'd2}, // R2 read by thread 0
        '{1'b1, 5'd15, 3'd1, 1'b0, 32'h1234_5FFF, 32'h9234_5000, 4'd3}, // R3 vector base
        '{1'b0, 5'd15, 3'd1, 1'b1, 32'h0,         32'h9234_5000, 4'd6}, // R6 same vp bank
        '{1'b1, 5'd2,  3'd2, 1'b1, 32'h0020_0001, 32'h0020_0001, 4'd6}, // R6 rebind thread 1
        '{1'b0, 5'd15, 3'd1, 1'b1, 32'h0,         32'h8000_0000, 4'd6}, // R6 vp bank 1
        '{1'b1, 5'd1,  3'd1, 1'b1, 32'hAAAA_5555, 32'hAAAA_5555, 4'd6}, // R6 vp ctrl bank 1
        '{1'b0, 5'd1,  3'd1, 1'b0, 32'h0,         32'h0000_0000, 4'd6}, // R6 vp ctrl bank 0
        '{1'b1, 5'd7,  3'd3, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9}, // R9 unmapped
        '{1'b1, 5'd16, 3'd2, 1'b0, 32'hFFFF_FFFF, 32'h7000_F000, 4'd3}, // R3 cfg2
        '{1'b1, 5'd2,  3'd4, 1'b1, 32'h0000_0001, 32'h0000_0001, 4'd5}, // R5 halt thread 1
        '{1'b0, 5'd2,  3'd4, 1'b0, 32'h0,         32'h0000_0000, 4'd5}, // R5 halt thread 0
        '{1'b1, 5'd3,  3'd0, 1'b0, 32'hFFFF_FFFF, 32'h3FFF_FFFF, 4'd1}  // R1 index 24
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [4:0] n, input logic [2:0] s, input logic [TW-1:0] t);
        rd_num = n;
        rd_sel = s;
        rd_tid = t;
        #1;
    endtask

    task automatic sw_wr(input logic [4:0] n, input logic [2:0] s, input logic [TW-1:0] t,
                         input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_num = n; sw_sel = s; sw_tid = t; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic raw_wr(input logic [4:0] n, input logic [2:0] s, input logic [TW-1:0] t,
                          input logic do_val, input logic [31:0] d,
                          input logic do_mask, input logic [31:0] m);
        @(negedge clk);
        raw_we = do_val; raw_mask_we = do_mask;
        raw_num = n; raw_sel = s; raw_tid = t; raw_wdata = d; raw_wmask = m;
        @(negedge clk);
        raw_we = 1'b0; raw_mask_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Mask readback straight after reset (R7).
        look(5'd12, 3'd0, 1'b0);
        check("R7 mode mask", rd_mask, 32'hFF78_FF17);
        look(5'd1, 3'd0, 1'b0);
        check("R7 random mask", rd_mask, 32'h0000_0000);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) sw_wr(VEC[i].num, VEC[i].sel, VEC[i].tid, VEC[i].data);
            look(VEC[i].num, VEC[i].sel, VEC[i].tid);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
        end

        // R1: neighbour index 16 untouched by the write to index 24.
        look(5'd2, 3'd0, 1'b0);
        check("R1 neighbour index 16", rd_data, 32'h0);

        // R8: privileged write bypasses the zero mask.
        raw_wr(5'd15, 3'd0, 1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'h0);
        look(5'd15, 3'd0, 1'b0);
        check("R8 raw value", rd_data, 32'hDEAD_BEEF);
        raw_wr(5'd15, 3'd0, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0000_FFFF);
        look(5'd15, 3'd0, 1'b0);
        check("R8 raw mask", rd_mask, 32'h0000_FFFF);
        check("R8 mask write keeps value", rd_data, 32'hDEAD_BEEF);
        sw_wr(5'd15, 3'd0, 1'b0, 32'h0);
        look(5'd15, 3'd0, 1'b0);
        check("R3 new mask applied", rd_data, 32'hDEAD_0000);

        // R8: same-cycle collision on one register, privileged wins.
        @(negedge clk);
        sw_we = 1'b1; sw_num = 5'd15; sw_sel = 3'd0; sw_tid = 1'b0; sw_wdata = 32'h0000_FFFF;
        raw_we = 1'b1; raw_num = 5'd15; raw_sel = 3'd0; raw_tid = 1'b0; raw_wdata = 32'h1111_2222;
        @(negedge clk);
        sw_we = 1'b0; raw_we = 1'b0;
        look(5'd15, 3'd0, 1'b0);
        check("R8 collision", rd_data, 32'h1111_2222);

        // R8: same cycle, different registers, both land.
        @(negedge clk);
        sw_we = 1'b1; sw_num = 5'd4; sw_sel = 3'd0; sw_tid = 1'b0; sw_wdata = 32'hFFFF_FFFF;
        raw_we = 1'b1; raw_num = 5'd8; raw_sel = 3'd0; raw_tid = 1'b0; raw_wdata = 32'h0000_BAD0;
        @(negedge clk);
        sw_we = 1'b0; raw_we = 1'b0;
        look(5'd4, 3'd0, 1'b0);
        check("R3 context beside raw", rd_data, 32'hFF80_0000);
        look(5'd8, 3'd0, 1'b0);
        check("R8 fault address raw", rd_data, 32'h0000_BAD0);

        // R6: out-of-range bank reads zero and ignores writes.
        raw_wr(5'd2, 3'd2, 1'b1, 1'b1, 32'h0020_0003, 1'b0, 32'h0);
        look(5'd1, 3'd1, 1'b1);
        check("R6 out of range read", rd_data, 32'h0);
        sw_wr(5'd1, 3'd1, 1'b1, 32'hFFFF_FFFF);
        look(5'd1, 3'd1, 1'b0);
        check("R6 bank 0 untouched", rd_data, 32'h0);
        raw_wr(5'd2, 3'd2, 1'b1, 1'b1, 32'h0020_0001, 1'b0, 32'h0);
        look(5'd1, 3'd1, 1'b1);
        check("R6 bank 1 untouched", rd_data, 32'hAAAA_5555);

        // R9: unmapped mask reads zero.
        look(5'd7, 3'd3, 1'b0);
        check("R9 unmapped mask", rd_mask, 32'h0);

        // R10: idle cycles change nothing.
        repeat (5) @(negedge clk);
        look(5'd0, 3'd0, 1'b0);
        check("R10 idle hold", rd_data, 32'h1234_5678);

        // R7: reset restores the start-up state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        look(5'd12, 3'd0, 1'b0);
        check("R7 mode after reset", rd_data, 32'h0040_0004);
        look(5'd0, 3'd0, 1'b0);
        check("R7 index after reset", rd_data, 32'h0);
        look(5'd15, 3'd0, 1'b0);
        check("R7 cpu id mask after reset", rd_mask, 32'h0);
        look(5'd2, 3'd2, 1'b1);
        check("R7 binding after reset", rd_data, 32'h0020_0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule